// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Validation

This block receives characters from an asynchronous serial line. It runs from a system clock and is paced by a single-cycle enable, `tick16`, that pulses sixteen times per bit period. The line is synchronized into the clock domain and watched for a high-to-low transition. Any such transition starts a tick counter. The line is then checked again at the centre of the start bit. A short low pulse that has ended by that point is treated as noise, and the receiver goes back to waiting.

After a start bit is accepted, the receiver samples the data bits at their centres, least significant bit first, into a shift register. It then samples the stop bit. The finished character moves into a holding register, and the data-ready flag is raised. The framing-error flag shows the state of that stop bit. If the interrupt enable input is high at the moment of transfer, an interrupt request is also raised. A read strobe consumes the character. A character that arrives while the previous one is still unread replaces it and raises an overrun flag.

Top module: `async_rx`

## Requirements
- R1: After reset, `dataReady`, `frameErr`, `overrun` and `rxIrq` are 0, `rxData` is 0x00, and the line is treated as idle high.
- R2: A falling edge on the synchronized `serialIn` starts a tick counter. The line is re-sampled on the 8th `tick16` pulse after that edge. If the line is high at that sample, no character is produced, and the outputs do not change.
- R3: The data bits are sampled every 16 ticks after the start-bit centre, least significant bit first (the first data bit after the start bit is bit 0 of `rxData`). `rxData` changes only when a character is transferred.
- R4: `dataReady` goes to 1 when a completed character is transferred to the holding register, and at no other time.
- R5: The stop bit is sampled 16 ticks after the last data bit. If it is 0, `frameErr` is 1 alongside `dataReady`. If it is 1, `frameErr` is 0 for that character.
- R6: `rxIrq` is set on a transfer only when `rxIntEn` is 1 in that cycle. With `rxIntEn` at 0, a transfer leaves `rxIrq` at 0.
- R7: A one-cycle `rdStrobe` clears `dataReady`, `rxIrq` and `overrun` on the next clock, unless a transfer happens in the same cycle.
- R8: A transfer while `dataReady` is 1 (and no read is in the same cycle) overwrites `rxData` with the new character and sets `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Asynchronous serial line, idles high |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rdStrobe | input | 1 | One-cycle read of the holding register |
| rxIntEn | input | 1 | Receive interrupt enable |
| rxData | output | 8 | Holding register contents |
| dataReady | output | 1 | Unread character present |
| frameErr | output | 1 | Last character had a low stop bit |
| overrun | output | 1 | A character was overwritten before it was read |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default parameters: 8 data bits, 16 ticks per bit, and a centre at tick 8. It drives `tick16` on every other clock, so one bit period is 32 clocks. With these settings, all 256 character values can be sent through the receiver, and the interrupt enable alternates by a bit pattern of the value. Low glitches of 1 to 5 ticks are applied, and each must be dropped. A frame with a low stop bit and a pair of back-to-back unread frames cover the framing and overrun flags.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_e;

  typedef struct packed {
    logic shiftEn;
    logic commit;
  } rxStrobe_t;
endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      lineSync,
  input  logic      fallEdge,
  output rxStrobe_t strobes
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] CENTER_LAST = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] BIT_LAST    = CW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] IDX_LAST    = BW'(DATA_BITS - 1);

  rxState_e state, stateNext;
  logic [CW-1:0] tickCnt, tickCntNext;
  logic [BW-1:0] bitIdx, bitIdxNext;

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitIdxNext  = bitIdx;
    strobes     = '0;
    unique case (state)
      ST_IDLE: begin
        if (fallEdge) begin
          stateNext   = ST_START;
          tickCntNext = '0;
        end
      end
      ST_START: begin
        if (tick16) begin
          if (tickCnt == CENTER_LAST) begin
            tickCntNext = '0;
            bitIdxNext  = '0;
            stateNext   = lineSync ? ST_IDLE : ST_DATA;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick16) begin
          if (tickCnt == BIT_LAST) begin
            tickCntNext     = '0;
            strobes.shiftEn = 1'b1;
            if (bitIdx == IDX_LAST) begin
              stateNext = ST_STOP;
            end else begin
              bitIdxNext = bitIdx + 1'b1;
            end
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick16) begin
          if (tickCnt == BIT_LAST) begin
            tickCntNext    = '0;
            strobes.commit = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitIdx  <= bitIdxNext;
    end
  end
endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 rdStrobe,
  input  logic                 rxIntEn,
  input  rxStrobe_t            strobes,
  output logic                 lineSync,
  output logic                 fallEdge,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataReady,
  output logic                 frameErr,
  output logic                 overrun,
  output logic                 rxIrq
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   linePrev;
  logic [DATA_BITS-1:0]   shiftReg;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= serialIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], serialIn};
      end
    end
  endgenerate

  assign lineSync = syncChain[SYNC_STAGES-1];
  assign fallEdge = linePrev & ~lineSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linePrev <= 1'b1;
      shiftReg <= '0;
    end else begin
      linePrev <= lineSync;
      if (strobes.shiftEn) shiftReg <= {lineSync, shiftReg[DATA_BITS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      dataReady <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
      rxIrq     <= 1'b0;
    end else if (strobes.commit) begin
      rxData    <= shiftReg;
      dataReady <= 1'b1;
      frameErr  <= ~lineSync;
      overrun   <= dataReady & ~rdStrobe;
      rxIrq     <= rxIntEn;
    end else if (rdStrobe) begin
      dataReady <= 1'b0;
      overrun   <= 1'b0;
      rxIrq     <= 1'b0;
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 tick16,
  input  logic                 rdStrobe,
  input  logic                 rxIntEn,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataReady,
  output logic                 frameErr,
  output logic                 overrun,
  output logic                 rxIrq
);
  rxStrobe_t strobes;
  logic      lineSync;
  logic      fallEdge;
  logic      commitStb;

  assign commitStb = strobes.commit;

  async_rx_ctrl #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16),
    .lineSync(lineSync), .fallEdge(fallEdge), .strobes(strobes)
  );

  async_rx_dp #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .rdStrobe(rdStrobe),
    .rxIntEn(rxIntEn), .strobes(strobes), .lineSync(lineSync),
    .fallEdge(fallEdge), .rxData(rxData), .dataReady(dataReady),
    .frameErr(frameErr), .overrun(overrun), .rxIrq(rxIrq)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdStrobe,
  input logic                 rxIntEn,
  input logic                 commitStb,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 dataReady,
  input logic                 overrun,
  input logic                 rxIrq
);
  p_ready_on_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> dataReady);

  p_ready_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(commitStb));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !commitStb |=> $stable(rxData));

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> (rxIrq == $past(rxIntEn)));

  p_irq_needs_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> dataReady);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !commitStb) |=> (!dataReady && !rxIrq && !overrun));

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && dataReady && !rdStrobe) |=> overrun);
endmodule

bind async_rx async_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rxIntEn(rxIntEn),
  .commitStb(commitStb), .rxData(rxData), .dataReady(dataReady),
  .overrun(overrun), .rxIrq(rxIrq)
);

// File: tb/async_rx_bench.sv
module async_rx_bench;
  localparam int BIT_CLKS = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b1;
  logic       tick16 = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       rxIntEn = 1'b0;
  logic [7:0] rxData;
  logic       dataReady, frameErr, overrun, rxIrq;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  async_rx u_async_rx (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .tick16(tick16),
    .rdStrobe(rdStrobe), .rxIntEn(rxIntEn), .rxData(rxData),
    .dataReady(dataReady), .frameErr(frameErr), .overrun(overrun),
    .rxIrq(rxIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic holdLine(input logic v, input int clks);
    serialIn = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopVal);
    holdLine(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) holdLine(b[i], BIT_CLKS);
    holdLine(stopVal, BIT_CLKS);
    holdLine(1'b1, BIT_CLKS);
  endtask

  task automatic doRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dataReady", dataReady, 0);
    check("R1 frameErr", frameErr, 0);
    check("R1 overrun", overrun, 0);
    check("R1 rxIrq", rxIrq, 0);
    check("R1 rxData", rxData, 0);
    holdLine(1'b1, 4 * BIT_CLKS);
    check("R1 idle line gives no data", dataReady, 0);

    // R3 R4 R5 R6 R7 sweep over every value
    for (int v = 0; v < 256; v++) begin
      logic en;
      en = v[0] ^ v[3];
      rxIntEn = en;
      sendFrame(8'(v), 1'b1);
      check("R3 data", rxData, v);
      check("R4 ready", dataReady, 1);
      check("R5 frame ok", frameErr, 0);
      check("R6 irq gate", rxIrq, int'(en));
      check("R8 no overrun", overrun, 0);
      doRead();
      check("R7 ready cleared", dataReady, 0);
      check("R7 irq cleared", rxIrq, 0);
    end

    // R2 glitches shorter than the centre are dropped
    held = rxData;
    rxIntEn = 1'b1;
    for (int g = 1; g <= 5; g++) begin
      holdLine(1'b0, 2 * g);
      holdLine(1'b1, 12 * BIT_CLKS);
      check("R2 glitch no ready", dataReady, 0);
      check("R2 glitch data kept", rxData, int'(held));
      check("R2 glitch no irq", rxIrq, 0);
    end
    sendFrame(8'hA5, 1'b1);
    check("R2 frame after glitch", rxData, 8'hA5);
    check("R2 ready after glitch", dataReady, 1);
    doRead();

    // R5 low stop bit
    sendFrame(8'h3C, 1'b0);
    check("R5 frame error", frameErr, 1);
    check("R5 ready with error", dataReady, 1);
    check("R5 data with error", rxData, 8'h3C);
    doRead();
    sendFrame(8'hC3, 1'b1);
    check("R5 error cleared", frameErr, 0);
    doRead();

    // R8 overrun
    sendFrame(8'h11, 1'b1);
    check("R8 first no overrun", overrun, 0);
    sendFrame(8'h22, 1'b1);
    check("R8 overrun set", overrun, 1);
    check("R8 data overwritten", rxData, 8'h22);
    check("R8 ready held", dataReady, 1);
    doRead();
    check("R7 overrun cleared", overrun, 0);
    check("R7 ready cleared after overrun", dataReady, 0);

    // R6 enable low keeps irq low
    rxIntEn = 1'b0;
    sendFrame(8'h5A, 1'b1);
    check("R6 irq disabled", rxIrq, 0);
    check("R6 ready without irq", dataReady, 1);
    doRead();

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule